// File: doc/BRIEF.md
# Programmable serial clock divider

This block derives the serial clock of a card-interface shift engine from the system clock by an integer divide ratio of two or more. Even and odd ratios are both supported. Alongside the clock it emits two single-cycle strobes, one in the cycle the serial clock goes high and one in the cycle it goes low. The shift engine uses these strobes to sample and to launch bits. The clock runs only while the shift engine holds its run request high. With the request low, the clock rests low.

The ratio is reached through one configuration word, split into two halves. On reads, the upper half reports the system clock frequency in MHz and the lower half reports the ratio chosen at build time. That build-time value always comes back, whatever was written last, so software can restore it. Writes carry only the new ratio. If a shift is running when the write arrives, the new ratio is held pending and takes effect once the run request drops. The build-time ratio is the smallest one that keeps the serial rate at or below the requested rate. The requested rate is itself limited to 25 MHz.

Top module: `sclk_divider`

## Requirements
- R1: After reset, `sclk_o`, `rise_stb_o` and `fall_stb_o` are 0, and the active ratio is the build-time ratio.
- R2: The build-time ratio is the smallest integer D of at least 2 for which SYS_CLK_MHZ / D does not exceed min(TARGET_MHZ, 25). With the defaults (100 MHz, 20 MHz) D is 5.
- R3: While `run_i` is high, the serial clock has a period of D system cycles. It is high for floor(D/2) cycles and low for ceil(D/2) cycles. The first rising edge shows at the outputs ceil(D/2) clock edges after the first edge that samples `run_i` high.
- R4: `rise_stb_o` is 1 only in the first cycle that `sclk_o` is high, and `fall_stb_o` is 1 only in the first cycle that `sclk_o` is low again. The two strobes are never 1 together.
- R5: One edge after `run_i` is sampled low, `sclk_o` and both strobes are 0, even if the clock was in its high phase. The next run starts again with a full low phase.
- R6: `cfg_rdata_o[REG_W-1:REG_W/2]` equals SYS_CLK_MHZ and `cfg_rdata_o[REG_W/2-1:0]` equals the build-time ratio, at all times and after any write.
- R7: When `cfg_wr_i` is high while idle, `cfg_wdata_i` becomes the active ratio. A run started two edges after the write uses the new ratio.
- R8: A ratio written while `run_i` is high does not change the running clock. It is applied once `run_i` is low. If several writes arrive, the last one wins.
- R9: Written ratios of 0 and 1 are treated as 2.
- R10: The full field range up to 2^(REG_W/2)-1 (255 by default) is usable as a ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Shift engine requests a running serial clock |
| cfg_wr_i | input | 1 | Write strobe for the ratio field |
| cfg_wdata_i | input | REG_W/2 | New divide ratio |
| cfg_rdata_o | output | REG_W | Readback: {system MHz, build-time ratio} |
| sclk_o | output | 1 | Serial clock, rests low |
| rise_stb_o | output | 1 | One-cycle pulse with each rising serial edge |
| fall_stb_o | output | 1 | One-cycle pulse with each falling serial edge |

## Verification
Each result has a known due cycle, counted in clock edges:
- An idle write reaches the active ratio after two edges: one to hold it pending and one to apply it.
- The first rising edge appears ceil(D/2) edges after `run_i` is first sampled high.
- Each strobe is registered together with `sclk_o`, so it appears in the same cycle as the edge it marks.
- A low `run_i` clears the outputs after a single edge.

The bench drives inputs on the falling clock edge and samples on the next falling edge. It counts those samples to measure the latency, the high run and the low run against D, and it waits the two edges before starting any run that should see a new ratio.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;

    // Upper bound on any requested serial rate, in MHz
    localparam int unsigned RATE_CAP_MHZ = 25;

    // Smallest ratio >= 2 keeping sys/ratio at or below the capped target
    function automatic int unsigned calc_default_div(
        input int unsigned sys_mhz,
        input int unsigned tgt_mhz,
        input int unsigned max_div
    );
        int unsigned tgt;
        int unsigned d;
        tgt = (tgt_mhz > RATE_CAP_MHZ) ? RATE_CAP_MHZ : tgt_mhz;
        if (tgt == 0) tgt = 1;
        d = (sys_mhz + tgt - 1) / tgt;
        if (d < 2) d = 2;
        if (d > max_div) d = max_div;
        return d;
    endfunction

endpackage

// File: rtl/sclk_div_cfg.sv
module sclk_div_cfg #(
    parameter int unsigned DIV_W   = 8,
    parameter logic [DIV_W-1:0] DEF_DIV = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             wr_i,
    input  logic [DIV_W-1:0] wdata_i,
    output logic [DIV_W-1:0] div_o
);

    localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);

    typedef struct packed {
        logic [DIV_W-1:0] active;
        logic [DIV_W-1:0] pend;
        logic             pend_vld;
    } cfg_state_t;

    cfg_state_t s_d, s_q;
    logic [DIV_W-1:0] wr_clamped;

    always_comb begin
        wr_clamped = (wdata_i < DIV_MIN) ? DIV_MIN : wdata_i;
        s_d = s_q;
        // Apply a pending ratio only while the shifter is idle
        if (!run_i && s_q.pend_vld) begin
            s_d.active   = s_q.pend;
            s_d.pend_vld = 1'b0;
        end
        // A newer write replaces whatever is pending
        if (wr_i) begin
            s_d.pend     = wr_clamped;
            s_d.pend_vld = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.active   <= DEF_DIV;
            s_q.pend     <= DEF_DIV;
            s_q.pend_vld <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign div_o = s_q.active;

    // R9
    div_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.active >= DIV_MIN);

    // R8
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |=> $stable(s_q.active));

endmodule

// File: rtl/sclk_phase_gen.sv
module sclk_phase_gen #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             sclk_o,
    output logic             rise_o,
    output logic             fall_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             sclk;
        logic             rise;
        logic             fall;
    } ph_state_t;

    ph_state_t s_d, s_q;
    logic [DIV_W-1:0] lo_len;
    logic [DIV_W-1:0] rise_at;
    logic [DIV_W-1:0] last_at;

    always_comb begin
        // Low phase gets the extra cycle of an odd ratio
        lo_len  = div_i - (div_i >> 1);
        rise_at = lo_len - 1'b1;
        last_at = div_i - 1'b1;
        s_d = s_q;
        if (!run_i) begin
            s_d.cnt  = '0;
            s_d.sclk = 1'b0;
            s_d.rise = 1'b0;
            s_d.fall = 1'b0;
        end else begin
            s_d.rise = (s_q.cnt == rise_at);
            s_d.fall = (s_q.cnt == last_at);
            s_d.sclk = (s_q.cnt >= rise_at) && (s_q.cnt != last_at);
            s_d.cnt  = (s_q.cnt == last_at) ? '0 : s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sclk_o = s_q.sclk;
    assign rise_o = s_q.rise;
    assign fall_o = s_q.fall;

    // R4
    stb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_q.rise && s_q.fall));

    // R4
    rise_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rise |-> (s_q.sclk && !$past(s_q.sclk)));

    // R4
    fall_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.fall |-> (!s_q.sclk && $past(s_q.sclk)));

    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (!s_q.sclk && !s_q.rise && !s_q.fall));

endmodule

// File: rtl/sclk_divider.sv
module sclk_divider #(
    parameter int unsigned SYS_CLK_MHZ = 100,
    parameter int unsigned TARGET_MHZ  = 20,
    parameter int unsigned REG_W       = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run_i,
    input  logic                 cfg_wr_i,
    input  logic [REG_W/2-1:0]   cfg_wdata_i,
    output logic [REG_W-1:0]     cfg_rdata_o,
    output logic                 sclk_o,
    output logic                 rise_stb_o,
    output logic                 fall_stb_o
);

    import sclk_div_pkg::*;

    localparam int unsigned DIV_W   = REG_W / 2;
    localparam int unsigned MAX_DIV = (1 << DIV_W) - 1;
    localparam logic [DIV_W-1:0] DEF_DIV =
        DIV_W'(calc_default_div(SYS_CLK_MHZ, TARGET_MHZ, MAX_DIV));
    localparam logic [DIV_W-1:0] FREQ_FIELD = DIV_W'(SYS_CLK_MHZ);

    logic [DIV_W-1:0] div_active;

    sclk_div_cfg #(
        .DIV_W   (DIV_W),
        .DEF_DIV (DEF_DIV)
    ) cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run_i),
        .wr_i    (cfg_wr_i),
        .wdata_i (cfg_wdata_i),
        .div_o   (div_active)
    );

    sclk_phase_gen #(
        .DIV_W (DIV_W)
    ) phase_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run_i),
        .div_i  (div_active),
        .sclk_o (sclk_o),
        .rise_o (rise_stb_o),
        .fall_o (fall_stb_o)
    );

    // Readback reports build-time constants only
    assign cfg_rdata_o = {FREQ_FIELD, DEF_DIV};

endmodule

// File: tb/sclk_divider_tb_top.sv
module sclk_divider_tb_top;

    localparam int unsigned NVEC = 6;
    localparam logic [7:0] WR_TAB  [0:NVEC-1] = '{8'd2, 8'd3, 8'd4, 8'd9, 8'd0, 8'd1};
    localparam int         EXP_TAB [0:NVEC-1] = '{2, 3, 4, 9, 2, 2};
    localparam logic [15:0] RD_EXP = {8'd100, 8'd5};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_i = 1'b0;
    logic       cfg_wr_i = 1'b0;
    logic [7:0] cfg_wdata_i = '0;
    logic [15:0] cfg_rdata_o;
    logic       sclk_o, rise_stb_o, fall_stb_o;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    sclk_divider dut_i (
        .clk (clk), .rst_n (rst_n), .run_i (run_i),
        .cfg_wr_i (cfg_wr_i), .cfg_wdata_i (cfg_wdata_i),
        .cfg_rdata_o (cfg_rdata_o), .sclk_o (sclk_o),
        .rise_stb_o (rise_stb_o), .fall_stb_o (fall_stb_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_write(input logic [7:0] v);
        cfg_wr_i = 1'b1;
        cfg_wdata_i = v;
        step();
        cfg_wr_i = 1'b0;
        step();
        step();
    endtask

    // Run one serial period; optional two writes during the low phase
    task automatic measure(input int d, input string tag, input bit do_wr,
                           input logic [7:0] w1, input logic [7:0] w2);
        int n = 0;
        int h = 0;
        int l = 0;
        run_i = 1'b1;
        do begin
            step();
            n++;
        end while (!rise_stb_o && n < 1000);
        check(n == d - d / 2, {tag, " first rise latency"}, n, d - d / 2);
        while (sclk_o && h < 1000) begin
            h++;
            step();
        end
        check(h == d / 2, {tag, " high phase"}, h, d / 2);
        check(fall_stb_o == 1'b1, {tag, " fall strobe"}, int'(fall_stb_o), 1);
        if (do_wr) begin
            cfg_wr_i = 1'b1;
            cfg_wdata_i = w1;
        end
        while (!rise_stb_o && l < 1000) begin
            l++;
            step();
            if (l == 1 && do_wr) cfg_wdata_i = w2;
            if (l == 2) cfg_wr_i = 1'b0;
        end
        cfg_wr_i = 1'b0;
        check(l == d - d / 2, {tag, " low phase"}, l, d - d / 2);
        run_i = 1'b0;
        step();
        check(!sclk_o && !rise_stb_o && !fall_stb_o, {tag, " R5 idle after run"},
              int'({sclk_o, rise_stb_o, fall_stb_o}), 0);
        step();
        step();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!sclk_o && !rise_stb_o && !fall_stb_o, "R1 outputs in reset",
              int'({sclk_o, rise_stb_o, fall_stb_o}), 0);
        rst_n = 1'b1;
        step();
        check(!sclk_o && !rise_stb_o && !fall_stb_o, "R1 outputs after reset",
              int'({sclk_o, rise_stb_o, fall_stb_o}), 0);
        // R6 readback of constants
        check(cfg_rdata_o == RD_EXP, "R6 readback at reset", cfg_rdata_o, RD_EXP);
        // R1 R2 build-time ratio is 5
        measure(5, "R1 R2 R3 default ratio", 1'b0, 8'd0, 8'd0);

        // Table walk: R3 R7 R9
        for (int i = 0; i < NVEC; i++) begin
            idle_write(WR_TAB[i]);
            measure(EXP_TAB[i], $sformatf("R3 R7 R9 vec%0d", i), 1'b0, 8'd0, 8'd0);
            check(cfg_rdata_o == RD_EXP, "R6 readback after write", cfg_rdata_o, RD_EXP);
        end

        // R10 top of field range
        idle_write(8'd255);
        measure(255, "R10 max ratio", 1'b0, 8'd0, 8'd0);

        // R8 writes during a run are deferred, last wins
        idle_write(8'd6);
        measure(6, "R8 old ratio kept", 1'b1, 8'd12, 8'd7);
        measure(7, "R8 last write applied", 1'b0, 8'd0, 8'd0);
        check(cfg_rdata_o == RD_EXP, "R6 readback after run write", cfg_rdata_o, RD_EXP);

        // R5 drop run in the middle of the high phase
        idle_write(8'd8);
        run_i = 1'b1;
        while (!rise_stb_o) step();
        step();
        check(sclk_o == 1'b1, "R5 still high", int'(sclk_o), 1);
        run_i = 1'b0;
        step();
        check(!sclk_o && !fall_stb_o, "R5 abort mid-high",
              int'({sclk_o, fall_stb_o}), 0);
        step();
        measure(8, "R5 restart full low phase", 1'b0, 8'd0, 8'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule